// File: doc/BRIEF.md
# Triggered Latency Pipeline and Event Buffer

This block sits behind the digitizers of a 16-channel front-end card. Every channel delivers a 12-bit sample on each sample strobe (one strobe per 50 ns sample period). All channels are recorded in parallel, one row per strobe, into a 128-row circular buffer. Capture runs without pause. A 1-bit local-trigger history is kept beside the sample rows and uses the same write pointer. An accept trigger arrives a programmable number of samples after the event it refers to. The block then looks back by that latency in the trigger history. If a local trigger is recorded there, the block copies an 8-sample window of all 16 channels into a four-event queue. If no local trigger is found, the accept trigger is discarded.

The queue is emptied through a valid/ready word stream. Each event starts with a header word, followed by 128 sample words. A slow reader stalls only the queue. A copy does not hold up capture, and neither does a stalled reader. An accept trigger that matches while the queue holds four events is dropped. The drop is counted in a saturating counter, and the next header that gets out is flagged.

Top module: `dcap_trig_buf`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, ovf_count is 0, the event number restarts at 0 and the local-trigger history is empty. A local trigger seen before reset cannot match an accept trigger after it.
- R2: On every strobe with smp_vld high, one row of all channels is written into the buffer. This happens whether or not events are being copied or the output is stalled. smp_in carries channel c at bits [12c+11:12c].
- R3: loc_trig and acc_trig are sampled only in a cycle with smp_vld high, and are ignored in all other cycles. Let n be the sample index of the strobe carrying acc_trig. With wide_cfg low, an event is taken only if loc_trig was high on the strobe of sample n-L, where L is lat_cfg.
- R4: With wide_cfg high, a local trigger on sample n-L-1, n-L or n-L+1 also causes a match. A local trigger two or more samples away does not.
- R5: A taken event holds samples n-L up to n-L+7 of every channel. The setting of lat_cfg must lie between 8 and 119.
- R6: An event is sent as one header word, with out_hdr high, followed by 128 sample words with out_hdr low. The sample words are time-major: for each of the 8 samples in order, channels 0 to 15. A sample word carries the sample in bits 11:0, and bits 15:12 are zero.
- R7: The queue holds at most 4 events. An accept trigger that matches while 4 events are held or in copy is dropped, and ovf_count rises by one, saturating at its maximum.
- R8: Header bit 15 is 1 when at least one matching accept trigger was dropped since the previous event was taken, and 0 otherwise.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and out_hdr hold steady. Words are sent in queue order, with none lost and none repeated.
- R10: An accept trigger without a matching local trigger produces no words and leaves ovf_count unchanged.
- R11: Header bits 14:0 carry the event number. It counts the events taken since reset, modulo 2^15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample period |
| smp_in | input | 192 | All 16 channel samples, channel c at bits 12c+11:12c |
| loc_trig | input | 1 | Local trigger for the sample in this strobe |
| acc_trig | input | 1 | Delayed accept trigger, given with a strobe |
| lat_cfg | input | 7 | Accept latency in samples |
| wide_cfg | input | 1 | Allow a match one sample early or late |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Reader takes the word |
| out_data | output | 16 | Header or sample word |
| out_hdr | output | 1 | Marks the header word |
| ovf_count | output | 16 | Saturating count of dropped events |

## Verification
The bench aims at the edges of the coincidence window. It places local triggers exactly at, one sample either side of, and two samples either side of the look-back point, with both the exact and the wide match setting. A design with an off-by-one look-back would emit events that were not expected, or miss events that were. The shortest and the longest allowed latency are both run. A wrong pointer offset in either case shows as shifted sample words. Long stretches of held-off out_ready fill the queue. A design that stalled capture, dropped the wrong event or lost the flag would deliver corrupted windows, a wrong drop count, or headers with the wrong bit 15. A reset in mid-run, with events still queued, checks that no old trigger history or event survives.

// File: rtl/dcap_pkg.sv
// Shared constants and helpers for the triggered capture block.
// Assumes the output word is wide enough to hold one sample.
package dcap_pkg;
    localparam int unsigned OUT_W = 16;

    // Builds a header word from the drop flag and the event number.
    function automatic logic [OUT_W-1:0] pack_hdr(input logic ovf,
                                                  input logic [OUT_W-2:0] evn);
        return {ovf, evn};
    endfunction
endpackage

// File: rtl/dcap_ring.sv
// Circular sample store with a local-trigger history at the same pointer.
// It writes one row per strobe and never stalls. It works out the look-back
// point for an accept trigger and the coincidence hit.
// Assumes: lat is at least 2, so the look-back point and its neighbours are
// already written. DEPTH is a power of two.
module dcap_ring #(
    parameter int unsigned NCH   = 16,
    parameter int unsigned SW    = 12,
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned RW   = NCH * SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [RW-1:0] smp_row,
    input  logic          loc_trig,
    input  logic          acc_trig,
    input  logic [AW-1:0] lat,
    input  logic          wide,
    input  logic [AW-1:0] rd_idx,
    output logic [RW-1:0] rd_row,
    output logic          hit,
    output logic [AW-1:0] base
);
    logic [RW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] hist;
    logic [AW-1:0]    wp;
    logic [AW-1:0]    bm1, bp1;

    // Sample rows: contents need no reset, they are valid once refilled.
    always_ff @(posedge clk) begin
        if (smp_vld) mem[wp] <= smp_row;
    end

    // Write pointer and trigger history advance on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            hist <= '0;
        end else if (smp_vld) begin
            wp       <= wp + 1'b1;
            hist[wp] <= loc_trig;
        end
    end

    // Look-back point and coincidence test for this strobe.
    always_comb begin
        base = wp - lat;
        bm1  = base - 1'b1;
        bp1  = base + 1'b1;
        hit  = smp_vld && acc_trig &&
               (hist[base] || (wide && (hist[bm1] || hist[bp1])));
    end

    // Read port used by the copy engine.
    assign rd_row = mem[rd_idx];
endmodule

// File: rtl/dcap_evq.sv
// Event queue with a copy engine. On a hit with a free slot, it copies WIN
// rows from the ring into the slot, one row per cycle, and writes the header.
// It drops a hit when all slots are reserved, and counts the drop.
// Assumes: strobes are more than WIN cycles apart, so a copy is done before
// the next hit. NEV is a power of two.
module dcap_evq
    import dcap_pkg::*;
#(
    parameter int unsigned NCH   = 16,
    parameter int unsigned SW    = 12,
    parameter int unsigned DEPTH = 128,
    parameter int unsigned WIN   = 8,
    parameter int unsigned NEV   = 4,
    parameter int unsigned CNTW  = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned RW   = NCH * SW,
    localparam int unsigned TW   = $clog2(WIN),
    localparam int unsigned SLW  = (NEV > 1) ? $clog2(NEV) : 1,
    localparam int unsigned CW   = $clog2(NEV + 1),
    localparam int unsigned MAW  = $clog2(NEV * WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [AW-1:0]    base,
    output logic [AW-1:0]    ring_idx,
    input  logic [RW-1:0]    ring_row,
    input  logic [TW-1:0]    rd_t,
    output logic [RW-1:0]    rd_row,
    output logic [OUT_W-1:0] rd_hdr,
    output logic             avail,
    input  logic             pop,
    output logic [CNTW-1:0]  ovf_count
);
    logic [RW-1:0]    mem [NEV*WIN];
    logic [OUT_W-1:0] hdr [NEV];
    logic             copying;
    logic [TW-1:0]    cp_t;
    logic [AW-1:0]    cp_base;
    logic [SLW-1:0]   wr_slot, rd_slot;
    logic [CW-1:0]    res_cnt, done_cnt;
    logic [OUT_W-2:0] evnum;
    logic             sticky;
    logic [CNTW-1:0]  ovf_cnt;
    logic             start, drop, fin;
    logic [MAW-1:0]   waddr, raddr;

    // Take a hit only when idle and a slot is free, otherwise drop it.
    always_comb begin
        start    = hit && !copying && (res_cnt != CW'(NEV));
        drop     = hit && !start;
        fin      = copying && (cp_t == TW'(WIN - 1));
        ring_idx = cp_base + AW'(cp_t);
        waddr    = MAW'(wr_slot) * MAW'(WIN) + MAW'(cp_t);
        raddr    = MAW'(rd_slot) * MAW'(WIN) + MAW'(rd_t);
    end

    // Copy rows and the header into the slot being filled.
    always_ff @(posedge clk) begin
        if (copying) mem[waddr] <= ring_row;
        if (start)   hdr[wr_slot] <= pack_hdr(sticky, evnum);
    end

    // Copy sequencer and write-slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copying <= 1'b0;
            cp_t    <= '0;
            cp_base <= '0;
            wr_slot <= '0;
        end else if (start) begin
            copying <= 1'b1;
            cp_t    <= '0;
            cp_base <= base;
        end else if (fin) begin
            copying <= 1'b0;
            wr_slot <= (wr_slot == SLW'(NEV - 1)) ? '0 : wr_slot + 1'b1;
        end else if (copying) begin
            cp_t <= cp_t + 1'b1;
        end
    end

    // Occupancy: reserved at start, complete at finish, freed at pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_cnt  <= '0;
            done_cnt <= '0;
            rd_slot  <= '0;
        end else begin
            res_cnt  <= res_cnt + CW'(start) - CW'(pop);
            done_cnt <= done_cnt + CW'(fin) - CW'(pop);
            if (pop) rd_slot <= (rd_slot == SLW'(NEV - 1)) ? '0 : rd_slot + 1'b1;
        end
    end

    // Event number, drop flag and saturating drop counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evnum   <= '0;
            sticky  <= 1'b0;
            ovf_cnt <= '0;
        end else begin
            if (start) begin
                evnum  <= evnum + 1'b1;
                sticky <= 1'b0;
            end
            if (drop) begin
                sticky <= 1'b1;
                if (ovf_cnt != '1) ovf_cnt <= ovf_cnt + 1'b1;
            end
        end
    end

    assign rd_row    = mem[raddr];
    assign rd_hdr    = hdr[rd_slot];
    assign avail     = (done_cnt != '0);
    assign ovf_count = ovf_cnt;

    // R7
    res_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_cnt <= CW'(NEV)) && (done_cnt <= res_cnt));
    // R7
    ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt == '1) |=> (ovf_cnt == '1));
    // R10
    ovf_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |=> (ovf_cnt == $past(ovf_cnt)));
    // R2
    no_busy_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !copying);
endmodule

// File: rtl/dcap_out.sv
// Output serializer. It walks the oldest complete event as one header word
// and then WIN*NCH sample words, time-major, under valid/ready.
// It pops the slot when the last word is taken.
// Assumes: the event slot it reads stays unchanged until it is popped.
module dcap_out
    import dcap_pkg::*;
#(
    parameter int unsigned NCH  = 16,
    parameter int unsigned SW   = 12,
    parameter int unsigned WIN  = 8,
    localparam int unsigned RW  = NCH * SW,
    localparam int unsigned TW  = $clog2(WIN),
    localparam int unsigned NW  = WIN * NCH,
    localparam int unsigned WW  = $clog2(NW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             avail,
    input  logic [OUT_W-1:0] hdr_word,
    input  logic [RW-1:0]    row,
    output logic [TW-1:0]    rd_t,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_hdr,
    output logic             pop
);
    logic [WW-1:0] widx, kidx;
    int unsigned   chi;
    logic          take;

    // Map the word index to a time row and a channel, and select the word.
    always_comb begin
        kidx      = (widx == '0) ? '0 : widx - 1'b1;
        rd_t      = TW'(kidx / WW'(NCH));
        chi       = int'(kidx % WW'(NCH));
        out_valid = avail;
        out_hdr   = (widx == '0);
        out_data  = out_hdr ? hdr_word
                            : {{(OUT_W - SW){1'b0}}, row[chi*SW +: SW]};
        take      = out_valid && out_ready;
        pop       = take && (widx == WW'(NW));
    end

    // Advance one word per handshake and wrap after the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    widx <= '0;
        else if (take) widx <= (widx == WW'(NW)) ? '0 : widx + 1'b1;
    end

    // R9
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_hdr)));
    // R6
    hdr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_hdr) |=> !out_hdr);
endmodule

// File: rtl/dcap_trig_buf.sv
// Top of the triggered capture block. It chains the ring, the event queue
// and the output serializer.
// Assumes: smp_vld pulses are more than WIN clock cycles apart, and lat_cfg
// lies in WIN..DEPTH-WIN-1.
module dcap_trig_buf
    import dcap_pkg::*;
#(
    parameter int unsigned NCH   = 16,
    parameter int unsigned SW    = 12,
    parameter int unsigned DEPTH = 128,
    parameter int unsigned WIN   = 8,
    parameter int unsigned NEV   = 4,
    parameter int unsigned CNTW  = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned RW   = NCH * SW,
    localparam int unsigned TW   = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [RW-1:0]    smp_in,
    input  logic             loc_trig,
    input  logic             acc_trig,
    input  logic [AW-1:0]    lat_cfg,
    input  logic             wide_cfg,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_hdr,
    output logic [CNTW-1:0]  ovf_count
);
    logic          hit, avail, pop;
    logic [AW-1:0] base, ring_idx;
    logic [RW-1:0] ring_row, q_row;
    logic [TW-1:0] rd_t;
    logic [OUT_W-1:0] q_hdr;

    dcap_ring #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_row(smp_in),
        .loc_trig(loc_trig), .acc_trig(acc_trig), .lat(lat_cfg),
        .wide(wide_cfg), .rd_idx(ring_idx), .rd_row(ring_row),
        .hit(hit), .base(base)
    );

    dcap_evq #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH), .WIN(WIN), .NEV(NEV),
               .CNTW(CNTW)) u_evq (
        .clk(clk), .rst_n(rst_n), .hit(hit), .base(base),
        .ring_idx(ring_idx), .ring_row(ring_row), .rd_t(rd_t),
        .rd_row(q_row), .rd_hdr(q_hdr), .avail(avail), .pop(pop),
        .ovf_count(ovf_count)
    );

    dcap_out #(.NCH(NCH), .SW(SW), .WIN(WIN)) u_out (
        .clk(clk), .rst_n(rst_n), .avail(avail), .hdr_word(q_hdr),
        .row(q_row), .rd_t(rd_t), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_hdr(out_hdr),
        .pop(pop)
    );

    // R5
    lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && acc_trig) |->
            (lat_cfg >= AW'(WIN) && lat_cfg <= AW'(DEPTH - WIN - 1)));
endmodule

// File: tb/dcap_trig_buf_bench.sv
module dcap_trig_buf_bench;
    localparam int NCH = 16;
    localparam int SW  = 12;
    localparam int NW  = 8 * NCH;
    localparam int PER = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic [NCH*SW-1:0] smp_in = '0;
    logic loc_trig = 1'b0, acc_trig = 1'b0;
    logic [6:0] lat_cfg = 7'd64;
    logic wide_cfg = 1'b0;
    logic out_valid, out_hdr;
    logic out_ready = 1'b0;
    logic [15:0] out_data;
    logic [15:0] ovf_count;

    int total = 0, bad = 0;
    int n = 0, cnt = 0, evn = 0, drops = 0, wpos = 0;
    bit sticky = 0;
    bit lth [1024];
    logic [16:0] exp_q [$];
    int unsigned salt;

    always #2 clk = ~clk;

    dcap_trig_buf u_dcap_trig_buf (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
        .loc_trig(loc_trig), .acc_trig(acc_trig), .lat_cfg(lat_cfg),
        .wide_cfg(wide_cfg), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_hdr(out_hdr), .ovf_count(ovf_count)
    );

    function automatic logic [11:0] smp_val(int idx, int ch);
        logic [31:0] x;
        x = (idx * 32'h9E3779B1) ^ (ch * 32'h85EBCA6B) ^ salt;
        x = x ^ (x >> 15);
        return x[11:0];
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_vld = 1'b0; acc_trig = 1'b0; loc_trig = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0; cnt = 0; evn = 0; drops = 0; wpos = 0; sticky = 0;
        foreach (lth[i]) lth[i] = 1'b0;
        exp_q.delete();
    endtask

    // Bench model of one accept at sample n.
    task automatic model_accept();
        int e;
        bit m;
        e = n - int'(lat_cfg);
        m = lth[e % 1024] || (wide_cfg && (lth[(e - 1) % 1024] || lth[(e + 1) % 1024]));
        if (!m) return;
        if (cnt < 4) begin
            exp_q.push_back({1'b1, sticky, 15'(evn)});
            for (int t = 0; t < 8; t++)
                for (int c = 0; c < NCH; c++)
                    exp_q.push_back({5'b0, smp_val(e + t, c)});
            cnt++; evn++; sticky = 0;
        end else begin
            if (drops < 65535) drops++;
            sticky = 1;
        end
    endtask

    // One clock: take a word if offered, drive stimulus, update the model.
    task automatic step(bit strobe, bit lt, bit acc, int rdy_pct);
        bit last;
        logic [16:0] e;
        last = 0;
        @(negedge clk);
        out_ready = (($urandom % 100) < rdy_pct);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9/R10 unexpected word", {out_hdr, out_data}, 0);
            end else begin
                e = exp_q.pop_front();
                if (e[16])
                    chk({out_hdr, out_data} == e, "R6/R8/R11 header", {out_hdr, out_data}, e);
                else
                    chk({out_hdr, out_data} == e, "R5/R6 sample", {out_hdr, out_data}, e);
            end
            wpos++;
            if (wpos == NW + 1) begin wpos = 0; last = 1; end
        end
        smp_vld = strobe;
        if (strobe) begin
            for (int c = 0; c < NCH; c++) smp_in[c*SW +: SW] = smp_val(n, c);
            loc_trig = lt; acc_trig = acc;
            if (acc) model_accept();
            lth[n % 1024] = lt;
            n++;
        end else begin
            smp_in = {6{$urandom}};
            loc_trig = $urandom % 2; acc_trig = $urandom % 2;
        end
        if (last) cnt--;
    endtask

    // mode 0: random triggers; mode 1: local every 20 samples, accepts near
    // the look-back point at offsets -2..+2 (R3, R4).
    task automatic run(int nstr, int lat, bit wide, int mode,
                       int lt_pct, int acc_pct, int rdy_pct);
        bit lt, acc;
        int r;
        @(negedge clk);
        lat_cfg = 7'(lat); wide_cfg = wide;
        for (int s = 0; s < nstr; s++) begin
            if (mode == 0) begin
                lt  = (($urandom % 100) < lt_pct);
                acc = (n >= lat + 2) && (($urandom % 100) < acc_pct);
            end else begin
                lt  = (n % 20 == 0);
                r   = (n - lat) % 20;
                acc = (n >= lat + 2) && (r <= 2 || r >= 18);
            end
            step(1'b1, lt, acc, rdy_pct);
            for (int k = 1; k < PER; k++) step(1'b0, 1'b0, 1'b0, rdy_pct);
        end
    endtask

    task automatic drain(string tag);
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 5000) begin
            step(1'b0, 1'b0, 1'b0, 100);
            guard++;
        end
        chk(exp_q.size() == 0, "R9 drain complete", exp_q.size(), 0);
        repeat (20) step(1'b0, 1'b0, 1'b0, 100);
        chk(out_valid == 1'b0, "R10 no extra event", out_valid, 0);
        chk(ovf_count == 16'(drops), tag, ovf_count, drops);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL R9 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        salt = $urandom(32'd4711);
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        chk(ovf_count == 16'd0, "R1 reset ovf_count", ovf_count, 0);
        // Main function under a stalling reader (R2, R3, R5).
        run(300, 64, 1'b0, 0, 30, 25, 70);
        drain("R7 drop count phase A");
        // Reader held off: fill the queue, drops and flag (R7, R8).
        run(120, 40, 1'b0, 0, 50, 70, 0);
        chk(drops > 0, "R7 drops occurred", drops, 1);
        chk(ovf_count == 16'(drops), "R7 drop count while full", ovf_count, drops);
        drain("R7 drop count phase B");
        // Neighbour offsets, wide match (R4) then exact match (R3).
        run(300, 20, 1'b1, 1, 0, 0, 90);
        drain("R4 drop count");
        run(200, 20, 1'b0, 1, 0, 0, 90);
        drain("R3 drop count");
        // Latency limits (R5).
        run(200, 8, 1'b0, 0, 40, 30, 80);
        drain("R5 drop count min latency");
        run(250, 119, 1'b1, 0, 40, 30, 80);
        drain("R5 drop count max latency");
        // Mid-run reset with queued events and dense triggers (R1, R11).
        run(100, 30, 1'b0, 0, 90, 60, 0);
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset drops queue", out_valid, 0);
        chk(ovf_count == 16'd0, "R1 reset clears count", ovf_count, 0);
        run(200, 30, 1'b1, 0, 40, 40, 60);
        drain("R1/R11 after reset");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule